// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block converts a 64-bit general-register value into an IEEE binary64 result. A two-bit type input says how to read the source: as a signed or unsigned integer, either 32 or 64 bits wide. A precision select picks one of two paths. The first gives a binary64 value directly. The second first rounds the value to binary32, then widens that binary32 value to binary64 with no further change.

The block normalises the source magnitude once. It then feeds two rounding units, one for each target precision. Rounding follows a two-bit mode input. The block reports the following:

- the result;
- a five-bit result class code;
- a flag saying the magnitude was rounded up;
- a flag saying the result is inexact;
- a sticky inexact flag;
- a one-cycle pulse that asks the owner to set the summary-exception bit.

The binary64 path from a 32-bit source can never be inexact. It writes only the result and leaves every status output as it was.

The caller strobes `in_valid` with a new operand. One clock later the registered outputs appear, together with `out_valid`.

Top module: `int2fp_conv`

## Requirements
- R1: `src_type` encodes 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit and 3 = unsigned 64-bit. For the two 32-bit types, bits 63:32 of `src_val` have no effect on any output.
- R2: With `to_single` = 0 and a 32-bit type, `result` is the exact binary64 value of the source integer.
- R3: With `to_single` = 0 and a 32-bit type, `class_code`, `frac_rounded`, `frac_inexact` and `sticky_inexact` keep their previous values, and `fx_set_pulse` stays 0.
- R4: A 64-bit type, or `to_single` = 1, rounds by `rnd_mode`: 00 = nearest-even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity.
- R5: On a rounding path, `frac_rounded` is 1 exactly when the magnitude was incremented, and `frac_inexact` is 1 exactly when the result differs from the source value.
- R6: An inexact rounding sets `sticky_inexact`, which stays 1 until reset. The same rounding raises `fx_set_pulse` for the one cycle in which `out_valid` is 1.
- R7: With `to_single` = 1, the value is rounded to binary32 and widened exactly to binary64. `result` bits 28:0 are therefore zero, and the class code describes the binary32 value.
- R8: On a rounding path, `class_code` is 00100 for a positive normal, 01000 for a negative normal and 00010 for +0.
- R9: A zero source gives +0, with `frac_rounded` and `frac_inexact` both 0.
- R10: A signed source converts its two's-complement magnitude and puts the sign in `result` bit 63. The value -2^63 converts exactly to -2^63.
- R11: `out_valid` is 1 in the cycle after each `in_valid` and 0 otherwise. Between strobes, `result` holds its value.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| src_val | input | 64 | Source integer |
| src_type | input | 2 | Source type: 0 s32, 1 u32, 2 s64, 3 u64 |
| to_single | input | 1 | 1 = round to binary32, then widen |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| out_valid | output | 1 | Outputs updated this cycle |
| result | output | 64 | binary64 result |
| class_code | output | 5 | Result class code |
| frac_rounded | output | 1 | Magnitude was incremented |
| frac_inexact | output | 1 | Result is not exact |
| sticky_inexact | output | 1 | Accumulated inexact flag |
| fx_set_pulse | output | 1 | One-cycle request to set the summary-exception bit |

## Verification
Every internal fault shows at the ports in the cycle after the strobe, because all arithmetic sits between the input and a single register stage.

- **Wrong leading-zero count or shift.** This corrupts the exponent and fraction bits of `result` at once.
- **Wrong guard or sticky selection.** This shows up in `frac_rounded` or `frac_inexact`, and in the low fraction bits, but only when the bits below the kept precision are non-zero.
- **Missing rounding carry.** This shows only for all-ones magnitudes, as an exponent that is one too small.
- **Status update on the exact path.** This is visible on the very next exact conversion, because the flags that should hold have changed.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;

  localparam int SRC_W = 64;
  localparam int LZ_W  = $clog2(SRC_W) + 1;

  typedef enum logic [1:0] {
    SRC_S32 = 2'd0,
    SRC_U32 = 2'd1,
    SRC_S64 = 2'd2,
    SRC_U64 = 2'd3
  } src_type_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rnd_mode_e;

  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;

  // Count of zero bits above the highest set bit; SRC_W for a zero value.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [SRC_W-1:0] v);
    lead_zeros = LZ_W'(SRC_W);
    for (int i = 0; i < SRC_W; i++) begin
      if (v[i]) lead_zeros = LZ_W'(SRC_W - 1 - i);
    end
  endfunction

  // Decide whether the truncated magnitude must be incremented.
  function automatic logic round_up(input rnd_mode_e mode, input logic sign,
                                    input logic lsb, input logic guard,
                                    input logic sticky);
    case (mode)
      RM_NEAR: round_up = guard & (sticky | lsb);
      RM_ZERO: round_up = 1'b0;
      RM_UP:   round_up = (guard | sticky) & ~sign;
      default: round_up = (guard | sticky) & sign;
    endcase
  endfunction

  // Class code for a value that can only be zero or normal.
  function automatic logic [4:0] class_of(input logic sign, input logic zero);
    if (zero)      class_of = CLS_POS_ZERO;
    else if (sign) class_of = CLS_NEG_NORM;
    else           class_of = CLS_POS_NORM;
  endfunction

endpackage

// File: rtl/int2fp_operand.sv
module int2fp_operand
  import int2fp_pkg::*;
(
  input  logic [SRC_W-1:0] src_val,
  input  logic [1:0]       src_type,
  output logic             sign,
  output logic [SRC_W-1:0] mag
);
  localparam int HALF_W = SRC_W / 2;

  logic [HALF_W-1:0] low_word;
  logic [HALF_W-1:0] low_neg;
  logic [SRC_W-1:0]  full_neg;

  assign low_word = src_val[HALF_W-1:0];
  assign low_neg  = HALF_W'(0) - low_word;
  assign full_neg = SRC_W'(0) - src_val;

  always_comb begin
    case (src_type_e'(src_type))
      SRC_S32: begin
        sign = low_word[HALF_W-1];
        mag  = {{HALF_W{1'b0}}, sign ? low_neg : low_word};
      end
      SRC_U32: begin
        sign = 1'b0;
        mag  = {{HALF_W{1'b0}}, low_word};
      end
      SRC_S64: begin
        sign = src_val[SRC_W-1];
        mag  = sign ? full_neg : src_val;
      end
      default: begin
        sign = 1'b0;
        mag  = src_val;
      end
    endcase
  end
endmodule

// File: rtl/int2fp_normalize.sv
module int2fp_normalize
  import int2fp_pkg::*;
(
  input  logic [SRC_W-1:0] mag,
  output logic             is_zero,
  output logic [LZ_W-1:0]  lz,
  output logic [SRC_W-1:0] norm
);
  assign lz      = lead_zeros(mag);
  assign is_zero = (mag == '0);
  assign norm    = mag << lz;
endmodule

// File: rtl/int2fp_round.sv
module int2fp_round
  import int2fp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11,
  parameter int BIAS   = 1023
) (
  input  logic [SRC_W-1:0] norm,
  input  logic [LZ_W-1:0]  lz,
  input  logic             sign,
  input  logic             is_zero,
  input  logic [1:0]       mode,
  output logic [EXP_W-1:0] exp_f,
  output logic [FRAC_W-1:0] frac_f,
  output logic             inc,
  output logic             inexact,
  output logic             carry
);
  localparam int KEEP_W = FRAC_W + 1;
  localparam int G_IDX  = SRC_W - 1 - KEEP_W;

  logic [KEEP_W-1:0] kept;
  logic              guard;
  logic              sticky;
  logic [KEEP_W:0]   sum;
  int                exp_int;

  assign kept    = norm[SRC_W-1 -: KEEP_W];
  assign guard   = norm[G_IDX];
  assign sticky  = |norm[G_IDX-1:0];
  assign inexact = guard | sticky;
  assign inc     = round_up(rnd_mode_e'(mode), sign, kept[0], guard, sticky);
  assign sum     = {1'b0, kept} + (KEEP_W+1)'(inc);
  assign carry   = sum[KEEP_W];

  always_comb begin
    exp_int = (SRC_W - 1) - int'(lz) + BIAS + int'(carry);
    exp_f   = is_zero ? '0 : EXP_W'(exp_int);
    frac_f  = carry ? '0 : sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/int2fp_conv.sv
module int2fp_conv
  import int2fp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src_val,
  input  logic [1:0]  src_type,
  input  logic        to_single,
  input  logic [1:0]  rnd_mode,
  output logic        out_valid,
  output logic [63:0] result,
  output logic [4:0]  class_code,
  output logic        frac_rounded,
  output logic        frac_inexact,
  output logic        sticky_inexact,
  output logic        fx_set_pulse
);
  localparam int DP_FRAC = 52;
  localparam int DP_EXP  = 11;
  localparam int DP_BIAS = 1023;
  localparam int SP_FRAC = 23;
  localparam int SP_EXP  = 8;
  localparam int SP_BIAS = 127;
  localparam int WIDEN_PAD = DP_FRAC - SP_FRAC;

  logic             op_sign;
  logic [SRC_W-1:0] op_mag;
  logic             is_zero;
  logic [LZ_W-1:0]  lz;
  logic [SRC_W-1:0] norm;

  int2fp_operand u_operand (
    .src_val (src_val),
    .src_type(src_type),
    .sign    (op_sign),
    .mag     (op_mag)
  );

  int2fp_normalize u_norm (
    .mag    (op_mag),
    .is_zero(is_zero),
    .lz     (lz),
    .norm   (norm)
  );

  // Per-target rounding results
  logic [DP_EXP-1:0]  dp_exp;
  logic [DP_FRAC-1:0] dp_frac;
  logic [SP_EXP-1:0]  sp_exp;
  logic [SP_FRAC-1:0] sp_frac;
  logic dp_inc, dp_inexact, dp_carry;
  logic sp_inc, sp_inexact, sp_carry;

  int2fp_round #(.FRAC_W(DP_FRAC), .EXP_W(DP_EXP), .BIAS(DP_BIAS)) u_round_dp (
    .norm(norm), .lz(lz), .sign(op_sign), .is_zero(is_zero), .mode(rnd_mode),
    .exp_f(dp_exp), .frac_f(dp_frac), .inc(dp_inc), .inexact(dp_inexact),
    .carry(dp_carry)
  );

  int2fp_round #(.FRAC_W(SP_FRAC), .EXP_W(SP_EXP), .BIAS(SP_BIAS)) u_round_sp (
    .norm(norm), .lz(lz), .sign(op_sign), .is_zero(is_zero), .mode(rnd_mode),
    .exp_f(sp_exp), .frac_f(sp_frac), .inc(sp_inc), .inexact(sp_inexact),
    .carry(sp_carry)
  );

  // Exact widening of the binary32 value
  logic [DP_EXP-1:0] sp_exp_wide;
  logic              sp_is_zero;
  assign sp_is_zero  = (sp_exp == '0);
  assign sp_exp_wide = sp_is_zero ? '0
                     : DP_EXP'(sp_exp) + DP_EXP'(DP_BIAS - SP_BIAS);

  // Named events for the checks below
  logic        res_sign;
  logic [63:0] sel_result;
  logic        sel_inc;
  logic        sel_inexact;
  logic [4:0]  sel_class;
  logic        flag_write;
  logic        rnd_carry;

  assign res_sign    = op_sign & ~is_zero;
  assign sel_result  = to_single ? {res_sign, sp_exp_wide, sp_frac, {WIDEN_PAD{1'b0}}}
                                 : {res_sign, dp_exp, dp_frac};
  assign sel_inc     = to_single ? sp_inc : dp_inc;
  assign sel_inexact = to_single ? sp_inexact : dp_inexact;
  assign rnd_carry   = to_single ? sp_carry : dp_carry;
  assign sel_class   = to_single ? class_of(res_sign, sp_is_zero)
                                 : class_of(res_sign, dp_exp == '0);
  assign flag_write  = in_valid & (src_type[1] | to_single);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      class_code     <= '0;
      frac_rounded   <= 1'b0;
      frac_inexact   <= 1'b0;
      sticky_inexact <= 1'b0;
      fx_set_pulse   <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      fx_set_pulse <= flag_write & sel_inexact;
      if (in_valid) result <= sel_result;
      if (flag_write) begin
        class_code   <= sel_class;
        frac_rounded <= sel_inc;
        frac_inexact <= sel_inexact;
        if (sel_inexact) sticky_inexact <= 1'b1;
      end
    end
  end

  // R11: a strobe is always answered on the next cycle
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11: no answer without a strobe
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3: status outputs hold when no rounding path was used
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_write |=> ($stable(class_code) && $stable(frac_rounded)
                     && $stable(frac_inexact) && !fx_set_pulse));
  // R5: an increment can only come from discarded bits
  a_r5_inc_needs_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_inc) |-> sel_inexact);
  // R6: sticky flag never clears outside reset
  a_r6_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sticky_inexact));
  // R6: pulse coincides with a reported inexact result
  a_r6_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fx_set_pulse |-> (out_valid && frac_inexact && sticky_inexact));
  // R10: normalisation leaves the leading one at the top
  a_r10_norm_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_zero) |-> norm[SRC_W-1]);
  // R9: a zero source never rounds
  a_r9_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_zero) |-> (!sel_inexact && !sel_inc && !rnd_carry));
  // R7: widened single results keep the padding bits clear
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && to_single) |-> (sel_result[WIDEN_PAD-1:0] == '0));
endmodule

// File: tb/int2fp_conv_tb.sv
module int2fp_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_val = '0;
  logic [1:0]  src_type = '0;
  logic        to_single = 1'b0;
  logic [1:0]  rnd_mode = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  class_code;
  logic        frac_rounded, frac_inexact, sticky_inexact, fx_set_pulse;

  int n_vec = 0;
  int n_bad = 0;

  // Expected held state
  logic [4:0] e_class = '0;
  logic       e_fr = 1'b0, e_fi = 1'b0, e_sticky = 1'b0;

  always #2.5 clk = ~clk;

  int2fp_conv dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_val(src_val),
    .src_type(src_type), .to_single(to_single), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .result(result), .class_code(class_code),
    .frac_rounded(frac_rounded), .frac_inexact(frac_inexact),
    .sticky_inexact(sticky_inexact), .fx_set_pulse(fx_set_pulse)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: division-style rounding on the magnitude, fw fraction bits
  function automatic void ref_round(input logic [63:0] m, input logic sign,
                                    input int fw, input logic [1:0] mode,
                                    output logic [63:0] frac, output int e,
                                    output logic inexact, output logic up);
    int msb = -1;
    logic [63:0] q, r, half;
    for (int i = 0; i < 64; i++) if (m[i]) msb = i;
    up = 1'b0; inexact = 1'b0; e = msb;
    if (msb < 0) begin frac = '0; return; end
    if (msb <= fw) begin
      q = m << (fw - msb); r = '0; half = '0;
    end else begin
      q = m >> (msb - fw);
      r = m & ((64'd1 << (msb - fw)) - 64'd1);
      half = 64'd1 << (msb - fw - 1);
    end
    inexact = (r != 0);
    case (mode)
      2'b00: up = (r > half) || (r == half && r != 0 && q[0]);
      2'b01: up = 1'b0;
      2'b10: up = inexact && !sign;
      default: up = inexact && sign;
    endcase
    q = q + 64'(up);
    if (q == (64'd1 << (fw + 1))) begin q = q >> 1; e = e + 1; end
    frac = q & ((64'd1 << fw) - 64'd1);
  endfunction

  task automatic apply(input logic [63:0] v, input logic [1:0] ty,
                       input logic sp, input logic [1:0] rm, input string tag);
    logic [63:0] m, frac, exp_res;
    logic sgn, ine, up, rounds;
    int e;
    longint sv;
    case (ty)
      2'd0: begin sv = longint'($signed(v[31:0])); sgn = sv < 0; m = sgn ? 64'(-sv) : 64'(sv); end
      2'd1: begin sgn = 1'b0; m = {32'd0, v[31:0]}; end
      2'd2: begin sgn = v[63]; m = sgn ? (64'd0 - v) : v; end
      default: begin sgn = 1'b0; m = v; end
    endcase
    if (m == 0) sgn = 1'b0;
    ref_round(m, sgn, sp ? 23 : 52, rm, frac, e, ine, up);
    if (m == 0) exp_res = '0;
    else if (sp) exp_res = {sgn, 11'(e + 1023), frac[22:0], 29'd0};
    else exp_res = {sgn, 11'(e + 1023), frac[51:0]};
    rounds = ty[1] | sp;
    if (rounds) begin
      e_class = (m == 0) ? 5'b00010 : (sgn ? 5'b01000 : 5'b00100);
      e_fr = up; e_fi = ine;
      if (ine) e_sticky = 1'b1;
    end
    @(negedge clk);
    src_val = v; src_type = ty; to_single = sp; rnd_mode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    src_val = $urandom();  // ignored while idle
    check64({tag, " R11 out_valid"}, 64'(out_valid), 64'd1);
    check64({tag, rounds ? " R4 result" : " R2 result"}, result, exp_res);
    check64({tag, rounds ? " R8 class" : " R3 class"}, 64'(class_code), 64'(e_class));
    check64({tag, " R5 rounded"}, 64'(frac_rounded), 64'(e_fr));
    check64({tag, " R5 inexact"}, 64'(frac_inexact), 64'(e_fi));
    check64({tag, " R6 sticky"}, 64'(sticky_inexact), 64'(e_sticky));
    check64({tag, " R6 pulse"}, 64'(fx_set_pulse), 64'(rounds && ine));
    @(negedge clk);
    check64({tag, " R11 idle"}, {63'd0, out_valid}, 64'd0);
    check64({tag, " R11 hold"}, result, exp_res);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check64("R12 reset outputs", {result}, 64'd0);
    check64("R12 reset flags", {57'd0, out_valid, class_code, frac_rounded,
            frac_inexact, sticky_inexact, fx_set_pulse} >> 0, 64'd0);
    rst_n = 1'b1;
    // R9 zero, R1 upper bits ignored for 32-bit types
    apply(64'h0, 2'd2, 1'b0, 2'd0, "R9 zero s64");
    apply(64'hDEAD_BEEF_0000_0000, 2'd0, 1'b0, 2'd0, "R1 R9 zero s32 junk");
    apply(64'hFFFF_FFFF_0000_0001, 2'd1, 1'b0, 2'd2, "R1 u32 junk");
    // R2 R3 exact 32-bit, flags untouched after an inexact one
    apply(64'h7FFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'd0, "R4 s64 max near");
    apply(64'h0000_0000_8000_0000, 2'd0, 1'b0, 2'd0, "R2 R3 s32 min");
    apply(64'h1234_5678_FFFF_FFFF, 2'd1, 1'b0, 2'd3, "R2 R3 u32 max");
    // R10 most negative 64-bit
    apply(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd1, "R10 s64 min");
    apply(64'h8000_0000_0000_0000, 2'd2, 1'b1, 2'd3, "R10 R7 s64 min sp");
    // R4 each mode, carry into exponent
    for (int md = 0; md < 4; md++) begin
      apply(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'(md), "R4 u64 ones");
      apply(64'hFFFF_FFFF_FFFF_FFFD, 2'd2, 1'b0, 2'(md), "R4 s64 -3");
      apply(64'h0000_0000_0100_0003, 2'd1, 1'b1, 2'(md), "R7 u32 sp tie");
      apply(64'h0000_0000_FF00_0001, 2'd0, 1'b1, 2'(md), "R7 s32 sp neg");
    end
    // R4 ties: nearest-even both directions
    apply(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd0, "R4 tie even down");
    apply(64'h0020_0000_0000_0003, 2'd3, 1'b0, 2'd0, "R4 tie even up");
    // Random mixture
    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      v = {32'($urandom()), 32'($urandom())} >> ($urandom() % 64);
      if ($urandom() % 2) v = 64'd0 - v;
      apply(v, 2'($urandom()), 1'($urandom()), 2'($urandom()), "R4 R5 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule